// File: doc/BRIEF.md
# Peak or Average Bin Reducer

This block turns a stream of 8-bit samples into one value per horizontal position (a "bin"). While a bin is open it keeps two summaries of its samples side by side: the largest sample so far, and the total of all samples together with how many there were. When the bin-end strobe arrives, a mode select chooses which summary the bin reports. High picks the largest sample. Low picks the mean, which a serial restoring divider computes one quotient bit per clock.

A bin holds from 2 to 217 samples, depending on how fast the trace sweeps. The bin-end strobe closes the bin made of the samples accepted in earlier cycles, and at the same edge the summaries restart. A sample strobe in the same cycle as bin-end becomes the first sample of the next bin. A closed bin waits in a one-entry slot until the result engine is free, so a bin that closes while a division is still running is not lost. Results leave the block in the order their bins closed, each as a single-cycle valid strobe with the value beside it.

Top module: `bin_reducer`

## Requirements
- R1: After reset, `y_vld_o` is 0 and `y_o` is 0.
- R2: When `peak_sel_i` is 1 in the bin-end cycle, the result is the largest sample of that bin.
- R3: When `peak_sel_i` is 0 in the bin-end cycle, the result is the sum of the bin's samples divided by their count, rounded down.
- R4: With the engine idle, a peak result is strobed two clock edges after the edge that samples bin-end.
- R5: With the engine idle, a mean result is strobed ten clock edges after the edge that samples bin-end: one edge to enter the engine, eight edges for quotient bits, and one edge to present the result.
- R6: A sample strobed in the same cycle as bin-end belongs to the next bin, not to the bin being closed.
- R7: `peak_sel_i` is used only in the bin-end cycle. Its value in other cycles has no effect on any result.
- R8: A bin that closes while the engine is busy is held and its result is delivered after the current one. Results appear in the order their bins closed, provided no more than one bin is waiting at a time.
- R9: `y_vld_o` is high for exactly one cycle per closed bin and is never high in two consecutive cycles.
- R10: Bins of 2 samples and of 217 samples both give exact results, including 217 samples of 255 (sum 55335, mean 255).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | 8 | Sample value, unsigned |
| bin_end_i | input | 1 | Closes the current bin |
| peak_sel_i | input | 1 | 1 selects the largest sample, 0 selects the mean; used only when bin-end is high |
| y_o | output | 8 | Result value, held between strobes |
| y_vld_o | output | 1 | One-cycle strobe marking a new result |

## Verification
A corrupt sum or count shows up as a wrong mean on the very next average-mode strobe, ten edges after bin-end. A bad largest-sample register shows up two edges after the next peak-mode bin-end. A divider with a wrong step count or a wrong restore step moves the strobe or changes the quotient, and the per-clock comparison against the reference model catches either on that cycle. If the waiting slot mishandles a bin that closes while the engine is busy, a result goes missing, is duplicated or comes out of order, and this shows up within the following twenty cycles.

// File: rtl/bin_reducer_pkg.sv
package bin_reducer_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_DIV  = 2'd1,
    ENG_PEAK = 2'd2
  } eng_state_e;
endpackage

// File: rtl/bin_accum.sv
module bin_accum #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int SUM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] pk_o,
  output logic [SUM_W-1:0]  sum_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [DATA_W-1:0] first_pk;
  logic [SUM_W-1:0]  first_sum;
  logic [CNT_W-1:0]  first_cnt;

  // value a fresh bin starts with when a sample coincides with the clear
  assign first_pk  = smp_vld_i ? smp_i : '0;
  assign first_sum = smp_vld_i ? SUM_W'(smp_i) : '0;
  assign first_cnt = smp_vld_i ? CNT_W'(1) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pk_o  <= '0;
      sum_o <= '0;
      cnt_o <= '0;
    end else if (clr_i) begin
      pk_o  <= first_pk;
      sum_o <= first_sum;
      cnt_o <= first_cnt;
    end else if (smp_vld_i) begin
      if (smp_i > pk_o) pk_o <= smp_i;
      sum_o <= sum_o + SUM_W'(smp_i);
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/restoring_div.sv
module restoring_div #(
  parameter int DEN_W = 8,
  parameter int Q_W   = 8,
  parameter int NUM_W = DEN_W + Q_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [Q_W-1:0]   q_o
);
  localparam int STEP_W = $clog2(Q_W + 1);

  logic [DEN_W:0]    rem_q;
  logic [Q_W-1:0]    lo_q;
  logic [DEN_W-1:0]  den_q;
  logic [STEP_W-1:0] step_q;
  logic [DEN_W:0]    trial;
  logic [DEN_W:0]    diff;
  logic              fits;

  assign trial = {rem_q[DEN_W-1:0], lo_q[Q_W-1]};
  assign fits  = trial >= {1'b0, den_q};
  assign diff  = trial - {1'b0, den_q};
  assign q_o   = lo_q;

  // quotient fits Q_W bits because the numerator is below den * 2^Q_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      lo_q   <= '0;
      den_q  <= '0;
      step_q <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      rem_q  <= {1'b0, num_i[NUM_W-1 -: DEN_W]};
      lo_q   <= num_i[Q_W-1:0];
      den_q  <= den_i;
      step_q <= STEP_W'(Q_W);
      done_o <= 1'b0;
    end else if (step_q != '0) begin
      rem_q  <= fits ? diff : trial;
      lo_q   <= {lo_q[Q_W-2:0], fits};
      step_q <= step_q - STEP_W'(1);
      done_o <= (step_q == STEP_W'(1));
    end else begin
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bin_reducer.sv
module bin_reducer
  import bin_reducer_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_SMP = 217
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic              bin_end_i,
  input  logic              peak_sel_i,
  output logic [DATA_W-1:0] y_o,
  output logic              y_vld_o
);
  localparam int CNT_W = $clog2(MAX_SMP + 1);
  localparam int SUM_W = DATA_W + CNT_W;

  logic [DATA_W-1:0] acc_pk;
  logic [SUM_W-1:0]  acc_sum;
  logic [CNT_W-1:0]  acc_cnt;

  logic              pend_vld;
  logic              pend_avg;
  logic [DATA_W-1:0] pend_pk;
  logic [SUM_W-1:0]  pend_sum;
  logic [CNT_W-1:0]  pend_cnt;

  eng_state_e        eng_state;
  logic              eng_avg;
  logic [DATA_W-1:0] eng_pk;
  logic [SUM_W-1:0]  eng_num;
  logic [CNT_W-1:0]  eng_den;
  logic              load;
  logic              div_done;
  logic [DATA_W-1:0] div_q;

  bin_accum #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W),
    .SUM_W (SUM_W)
  ) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_vld_i(smp_vld_i),
    .smp_i    (smp_i),
    .clr_i    (bin_end_i),
    .pk_o     (acc_pk),
    .sum_o    (acc_sum),
    .cnt_o    (acc_cnt)
  );

  assign load = (eng_state == ENG_IDLE) && pend_vld;

  // one-entry slot for a closed bin waiting on the engine
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld <= 1'b0;
      pend_avg <= 1'b0;
      pend_pk  <= '0;
      pend_sum <= '0;
      pend_cnt <= '0;
    end else if (bin_end_i) begin
      pend_vld <= 1'b1;
      pend_avg <= !peak_sel_i;
      pend_pk  <= acc_pk;
      pend_sum <= acc_sum;
      pend_cnt <= acc_cnt;
    end else if (load) begin
      pend_vld <= 1'b0;
    end
  end

  restoring_div #(
    .DEN_W(CNT_W),
    .Q_W  (DATA_W),
    .NUM_W(SUM_W)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(load && pend_avg),
    .num_i  (pend_sum),
    .den_i  (pend_cnt),
    .done_o (div_done),
    .q_o    (div_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_state <= ENG_IDLE;
      eng_avg   <= 1'b0;
      eng_pk    <= '0;
      eng_num   <= '0;
      eng_den   <= '0;
      y_o       <= '0;
      y_vld_o   <= 1'b0;
    end else begin
      y_vld_o <= 1'b0;
      unique case (eng_state)
        ENG_IDLE: begin
          if (load) begin
            eng_avg   <= pend_avg;
            eng_pk    <= pend_pk;
            eng_num   <= pend_sum;
            eng_den   <= pend_cnt;
            eng_state <= pend_avg ? ENG_DIV : ENG_PEAK;
          end
        end
        ENG_PEAK: begin
          y_o       <= eng_pk;
          y_vld_o   <= 1'b1;
          eng_state <= ENG_IDLE;
        end
        ENG_DIV: begin
          if (div_done) begin
            y_o       <= div_q;
            y_vld_o   <= 1'b1;
            eng_state <= ENG_IDLE;
          end
        end
        default: eng_state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bin_reducer_chk.sv
module bin_reducer_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int SUM_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_vld_i,
  input logic [DATA_W-1:0] smp_i,
  input logic              bin_end_i,
  input logic [DATA_W-1:0] y_o,
  input logic              y_vld_o,
  input logic [DATA_W-1:0] acc_pk,
  input logic [CNT_W-1:0]  acc_cnt,
  input logic              pend_vld,
  input logic              eng_avg,
  input logic [SUM_W-1:0]  eng_num,
  input logic [CNT_W-1:0]  eng_den
);
  localparam int P_W = SUM_W + 2;

  logic [P_W-1:0] lo_p;
  logic [P_W-1:0] hi_p;

  assign lo_p = P_W'(y_o) * P_W'(eng_den);
  assign hi_p = lo_p + P_W'(eng_den);

  a_r9_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_vld_o |=> !y_vld_o);

  a_r3_mean_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_vld_o && eng_avg) |-> (lo_p <= P_W'(eng_num)) && (P_W'(eng_num) < hi_p));

  a_r2_peak_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && !bin_end_i) |=> (acc_pk >= $past(smp_i)));

  a_r6_new_bin_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bin_end_i |=> (acc_cnt == ($past(smp_vld_i) ? CNT_W'(1) : CNT_W'(0))));

  a_r8_end_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bin_end_i |=> pend_vld);
endmodule

bind bin_reducer bin_reducer_chk #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W),
  .SUM_W (SUM_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .smp_vld_i(smp_vld_i),
  .smp_i    (smp_i),
  .bin_end_i(bin_end_i),
  .y_o      (y_o),
  .y_vld_o  (y_vld_o),
  .acc_pk   (acc_pk),
  .acc_cnt  (acc_cnt),
  .pend_vld (pend_vld),
  .eng_avg  (eng_avg),
  .eng_num  (eng_num),
  .eng_den  (eng_den)
);

// File: tb/bin_reducer_tb_top.sv
`timescale 1ns/1ps
module bin_reducer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_vld = 1'b0;
  logic [7:0] smp = '0;
  logic       bin_end = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] y;
  logic       y_vld;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  int m_sum, m_cnt, m_pk;
  bit m_pend;
  int m_pend_y, m_pend_avg;
  int m_left, m_eng_y;
  bit m_vld;
  int m_y;

  always #2.5 clk = ~clk;

  bin_reducer dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .smp_vld_i (smp_vld),
    .smp_i     (smp),
    .bin_end_i (bin_end),
    .peak_sel_i(sel),
    .y_o       (y),
    .y_vld_o   (y_vld)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sum = 0; m_cnt = 0; m_pk = 0; m_pend = 0; m_pend_y = 0;
      m_pend_avg = 0; m_left = 0; m_eng_y = 0; m_vld = 0; m_y = 0;
    end else begin
      m_vld = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin m_vld = 1; m_y = m_eng_y; end
      end else if (m_pend) begin
        m_pend = 0;
        m_eng_y = m_pend_y;
        m_left = m_pend_avg ? 9 : 1;
      end
      if (bin_end) begin
        m_pend = 1;
        m_pend_avg = !sel;
        m_pend_y = sel ? m_pk : (m_cnt ? m_sum / m_cnt : 255);
        m_sum = smp_vld ? int'(smp) : 0;
        m_pk = smp_vld ? int'(smp) : 0;
        m_cnt = smp_vld ? 1 : 0;
      end else if (smp_vld) begin
        m_sum += smp;
        m_cnt++;
        if (smp > m_pk) m_pk = smp;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(y_vld == m_vld, {cur_req, " strobe"}, y_vld, m_vld);
      if (m_vld) check(y == 8'(m_y), {cur_req, " value"}, y, m_y);
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic cyc(input bit v, input int d, input bit be, input bit s);
    smp_vld = v; smp = 8'(d); bin_end = be; sel = s;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, sel);
  endtask

  // after a bin-end cycle, count edges to the strobe
  task automatic latency(input int exp, input string req);
    int got = -1;
    for (int k = 1; k <= 14; k++) begin
      cyc(0, 0, 0, 0);
      if (y_vld && got < 0) got = k;
    end
    check(got == exp, req, got, exp);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    cur_req = "R1";
    check(y_vld == 1'b0, "R1 vld", y_vld, 0);
    check(y == 8'd0, "R1 y", y, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(y_vld == 1'b0 && y == 8'd0, "R1 after release", y, 0);

    // R2 peak
    cur_req = "R2";
    cyc(1, 3, 0, 0); cyc(1, 200, 0, 0); cyc(1, 17, 0, 0); cyc(1, 90, 0, 0);
    cyc(0, 0, 1, 1);
    latency(2, "R4 peak latency");
    idle(2);

    // R3 average: 10+20+31 = 61, /3 = 20
    cur_req = "R3";
    cyc(1, 10, 0, 1); cyc(1, 20, 0, 1); cyc(1, 31, 0, 1);
    cyc(0, 0, 1, 0);
    latency(10, "R5 mean latency");
    idle(2);

    // R7: select toggles inside the bin, only the bin-end value counts
    cur_req = "R7";
    cyc(1, 7, 0, 1); cyc(1, 250, 0, 1); cyc(1, 9, 0, 0);
    cyc(0, 0, 1, 0);   // mean: 266/3 = 88
    idle(14);
    cyc(1, 5, 0, 0); cyc(1, 6, 0, 0);
    cyc(0, 0, 1, 1);   // peak 6
    idle(6);

    // R6: sample on the bin-end cycle opens the next bin
    cur_req = "R6";
    cyc(1, 100, 0, 1); cyc(1, 2, 0, 1);
    cyc(1, 255, 1, 1);  // closes {100,2}: peak 100
    cyc(1, 1, 0, 1);
    cyc(0, 0, 1, 0);    // closes {255,1}: mean 128
    idle(14);

    // R10: 217 samples of 255, then a 2-sample bin 0,1
    cur_req = "R10";
    for (int i = 0; i < 217; i++) cyc(1, 255, 0, 0);
    cyc(0, 0, 1, 0);
    idle(14);
    cyc(1, 0, 0, 0); cyc(1, 1, 0, 0);
    cyc(0, 0, 1, 0);
    idle(14);
    for (int i = 0; i < 217; i++) cyc(1, (i * 37) % 256, 0, 1);
    cyc(0, 0, 1, 0);
    idle(14);

    // R8: second bin closes while the divider runs
    cur_req = "R8";
    cyc(1, 40, 0, 0); cyc(1, 60, 0, 0);
    cyc(1, 11, 1, 0);  // mean 50
    cyc(1, 13, 0, 0);
    cyc(0, 0, 1, 1);   // peak 13, waits for divider
    idle(24);
    cyc(1, 200, 0, 1); cyc(1, 100, 0, 1);
    cyc(0, 0, 1, 1);   // peak 200
    cyc(1, 3, 0, 0); cyc(1, 4, 0, 0);
    cyc(0, 0, 1, 0);   // mean 3, waits one cycle
    idle(20);

    // R9 and mixed traffic: random bins, at most one waiting
    cur_req = "R9";
    for (int b = 0; b < 300; b++) begin
      int n = 2 + int'($urandom_range(0, 40));
      bit s = 1'($urandom_range(0, 1));
      for (int i = 0; i < n; i++) begin
        if ($urandom_range(0, 3) == 0) cyc(0, 0, 0, 1'($urandom_range(0, 1)));
        cyc(1, int'($urandom_range(0, 255)), 0, 1'($urandom_range(0, 1)));
      end
      cyc(0, 0, 1, s);
      idle(11);
    end
    idle(12);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule